// File: doc/BRIEF.md
# Framed Timeslot Bit Extractor

This block taps a data link channel out of a framed serial TDM receive stream. It runs on the system clock. A bit-time strobe marks each cycle that carries a new serial bit, and a frame sync marks the first bit of every frame. The block counts bit positions inside the frame and keeps track of whether the current frame is odd or even. It forwards only the bits of one chosen timeslot whose positions are enabled in an 8-bit mask, and only in frames of the chosen parity. The output goes to a downstream HDLC receiver as a serial bit with a one-cycle valid strobe.

Two frame layouts are supported. The 32-slot layout has 256 bits per frame, with no framing bit. The 24-slot layout has 193 bits per frame, and position 0 is a framing bit. The configuration inputs are static. The block samples them on every frame sync, so a change takes effect only at a frame boundary.

Top module: `dl_slot_extract`

## Requirements
- R1: During reset and after reset, `linkValid` is 0, and no bit is forwarded until the first frame sync has been seen while `bitTick` is high.
- R2: The bit sampled on a `bitTick` cycle that has `frameSync` high is frame position 0. Each later `bitTick` advances the position by one. In the 32-slot layout (`cfgT1`=0), timeslot k occupies positions 8k to 8k+7. A forwarded bit appears as `linkData` with `linkValid` high for exactly one cycle, in the cycle after its `bitTick` cycle.
- R3: Within a timeslot, the first bit received is numbered 7 and the last is numbered 0. Bit n is forwarded only when `cfgMask[n]` is 1.
- R4: The frame that starts at the first sync after reset is odd, and parity toggles at every later sync. `cfgOdd` allows extraction in odd frames and `cfgEven` allows it in even frames.
- R5: With `cfgEnable` at 0, no bit is forwarded.
- R6: In the 24-slot layout, a `cfgSlot` value of 24 or more forwards nothing. Positions at or beyond the frame length (256 or 193) forward nothing until the next sync. A sync that arrives early restarts the count at position 0.
- R7: All configuration inputs are sampled on the sync bit time. Changes made in the middle of a frame have no effect until the next sync.
- R8: In the 24-slot layout (`cfgT1`=1), position 0 is the framing bit and is never forwarded, and timeslot k occupies positions 8k+1 to 8k+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | High on cycles that carry a new serial bit |
| frameSync | input | 1 | Marks the first bit of a frame (valid with bitTick) |
| serData | input | 1 | Serial receive data |
| cfgT1 | input | 1 | 1: 24-slot 193-bit layout, 0: 32-slot 256-bit layout |
| cfgEven | input | 1 | Extract in even frames |
| cfgOdd | input | 1 | Extract in odd frames |
| cfgEnable | input | 1 | Channel enable |
| cfgSlot | input | 5 | Timeslot carrying the link |
| cfgMask | input | 8 | Per-bit enable, bit 7 = first bit of slot |
| linkData | output | 1 | Extracted bit |
| linkValid | output | 1 | One-cycle strobe qualifying linkData |

## Verification
A frame sync can arrive on the same bit time as an extracted bit. When it does, the parity toggle, the configuration sample and the position restart all have to apply to that very bit. The bench provokes this by programming slot 0 with bit 7 enabled in the 32-slot layout, and by ending frames early so that a sync interrupts a partly extracted slot. It also changes the configuration in the middle of a frame and sends a sync together with new settings. A behavioural model that runs every clock judges each of these cases, and pulse counts per frame back up the model.

// File: rtl/dl_slot_pkg.sv
package dl_slot_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // forward the bit sampled this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/dl_slot_ctrl.sv
module dl_slot_ctrl
  import dl_slot_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int E1_SLOTS  = 32,
  parameter int T1_SLOTS  = 24
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            bitTick,
  input  logic                            frameSync,
  input  logic                            cfgT1,
  input  logic                            cfgEven,
  input  logic                            cfgOdd,
  input  logic                            cfgEnable,
  input  logic [$clog2(E1_SLOTS)-1:0]     cfgSlot,
  input  logic [SLOT_BITS-1:0]            cfgMask,
  output ctlStrobe_t                      strobe
);
  localparam int SLOT_W  = $clog2(E1_SLOTS);
  localparam int BIT_W   = $clog2(SLOT_BITS);
  localparam int E1_LEN  = E1_SLOTS * SLOT_BITS;
  localparam int T1_LEN  = T1_SLOTS * SLOT_BITS + 1;
  localparam int POS_W   = $clog2(E1_LEN + 1);
  localparam int SIDX_W  = POS_W - BIT_W;

  logic [POS_W-1:0]  posCnt, curPos, dataPos, frameLen;
  logic              oddReg, alignedReg, curOdd, curAligned, syncNow;
  logic              shT1, shEven, shOdd, shEn;
  logic [SLOT_W-1:0] shSlot;
  logic [SLOT_BITS-1:0] shMask;
  logic              effT1, effEven, effOdd, effEn;
  logic [SLOT_W-1:0] effSlot;
  logic [SLOT_BITS-1:0] effMask;
  logic [SIDX_W-1:0] slotIdx;
  logic [BIT_W-1:0]  bitNum;
  logic              inFrame, slotLegal, slotHit, maskHit, parityOk;

  assign syncNow = bitTick & frameSync;

  // settings in force for this bit: fresh ones on the sync bit itself
  always_comb begin
    effT1   = syncNow ? cfgT1     : shT1;
    effEven = syncNow ? cfgEven   : shEven;
    effOdd  = syncNow ? cfgOdd    : shOdd;
    effEn   = syncNow ? cfgEnable : shEn;
    effSlot = syncNow ? cfgSlot   : shSlot;
    effMask = syncNow ? cfgMask   : shMask;
  end

  always_comb begin
    frameLen   = effT1 ? POS_W'(T1_LEN) : POS_W'(E1_LEN);
    curPos     = syncNow ? '0 : posCnt;
    curOdd     = syncNow ? ~oddReg : oddReg;
    curAligned = syncNow | alignedReg;
    inFrame    = (curPos < frameLen) && !(effT1 && curPos == '0);
    dataPos    = effT1 ? curPos - POS_W'(1) : curPos;
    slotIdx    = dataPos[POS_W-1:BIT_W];
    bitNum     = BIT_W'(SLOT_BITS - 1) - dataPos[BIT_W-1:0];
    slotLegal  = effT1 ? (int'(effSlot) < T1_SLOTS) : (int'(effSlot) < E1_SLOTS);
    slotHit    = (slotIdx == SIDX_W'(effSlot));
    maskHit    = effMask[bitNum];
    parityOk   = curOdd ? effOdd : effEven;
    strobe.capture = bitTick & curAligned & effEn & parityOk & inFrame
                   & slotLegal & slotHit & maskHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt     <= '0;
      oddReg     <= 1'b0;
      alignedReg <= 1'b0;
      shT1       <= 1'b0;
      shEven     <= 1'b0;
      shOdd      <= 1'b0;
      shEn       <= 1'b0;
      shSlot     <= '0;
      shMask     <= '0;
    end else if (bitTick) begin
      posCnt     <= (curPos < frameLen) ? curPos + POS_W'(1) : frameLen;
      oddReg     <= curOdd;
      alignedReg <= curAligned;
      if (syncNow) begin
        shT1   <= cfgT1;
        shEven <= cfgEven;
        shOdd  <= cfgOdd;
        shEn   <= cfgEnable;
        shSlot <= cfgSlot;
        shMask <= cfgMask;
      end
    end
  end
endmodule

// File: rtl/dl_slot_dpath.sv
module dl_slot_dpath
  import dl_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serData,
  input  ctlStrobe_t strobe,
  output logic       linkData,
  output logic       linkValid
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkData  <= 1'b0;
      linkValid <= 1'b0;
    end else begin
      linkValid <= strobe.capture;
      if (strobe.capture) linkData <= serData;
    end
  end
endmodule

// File: rtl/dl_slot_extract.sv
module dl_slot_extract
  import dl_slot_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int E1_SLOTS  = 32,
  parameter int T1_SLOTS  = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        bitTick,
  input  logic                        frameSync,
  input  logic                        serData,
  input  logic                        cfgT1,
  input  logic                        cfgEven,
  input  logic                        cfgOdd,
  input  logic                        cfgEnable,
  input  logic [$clog2(E1_SLOTS)-1:0] cfgSlot,
  input  logic [SLOT_BITS-1:0]        cfgMask,
  output logic                        linkData,
  output logic                        linkValid
);
  ctlStrobe_t strobe;

  dl_slot_ctrl #(
    .SLOT_BITS(SLOT_BITS), .E1_SLOTS(E1_SLOTS), .T1_SLOTS(T1_SLOTS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameSync(frameSync),
    .cfgT1(cfgT1), .cfgEven(cfgEven), .cfgOdd(cfgOdd),
    .cfgEnable(cfgEnable), .cfgSlot(cfgSlot), .cfgMask(cfgMask),
    .strobe(strobe)
  );

  dl_slot_dpath u_dpath (
    .clk(clk), .rstN(rstN), .serData(serData), .strobe(strobe),
    .linkData(linkData), .linkValid(linkValid)
  );
endmodule

// File: rtl/dl_slot_chk.sv
module dl_slot_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic frameSync,
  input logic serData,
  input logic cfgT1,
  input logic cfgEnable,
  input logic linkData,
  input logic linkValid
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !linkValid);

  p_valid_after_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> $past(bitTick));

  p_data_is_sampled_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> linkData == $past(serData));

  p_disabled_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && frameSync && !cfgEnable) |=> !linkValid);

  p_framing_bit_dropped_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && frameSync && cfgT1) |=> !linkValid);
endmodule

bind dl_slot_extract dl_slot_chk u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameSync(frameSync),
  .serData(serData), .cfgT1(cfgT1), .cfgEnable(cfgEnable),
  .linkData(linkData), .linkValid(linkValid)
);

// File: tb/sim_dl_slot_extract.sv
`timescale 1ns/1ps
module sim_dl_slot_extract;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, frameSync = 1'b0, serData = 1'b0;
  logic cfgT1 = 1'b0, cfgEven = 1'b0, cfgOdd = 1'b0, cfgEnable = 1'b0;
  logic [4:0] cfgSlot = '0;
  logic [7:0] cfgMask = '0;
  logic linkData, linkValid;

  int compared = 0, mismatched = 0, pulseCnt = 0;
  string phase = "R1";

  always #(CLK_P/2) clk = ~clk;

  dl_slot_extract u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameSync(frameSync),
    .serData(serData), .cfgT1(cfgT1), .cfgEven(cfgEven), .cfgOdd(cfgOdd),
    .cfgEnable(cfgEnable), .cfgSlot(cfgSlot), .cfgMask(cfgMask),
    .linkData(linkData), .linkValid(linkValid)
  );

  // behavioural reference model
  int  mPos = 0;
  bit  mOdd = 0, mAligned = 0;
  bit  sT1 = 0, sEven = 0, sOdd = 0, sEn = 0;
  int  sSlot = 0;
  bit [7:0] sMask = 0;
  logic expValid = 1'b0, expData = 1'b0;

  always @(posedge clk) begin
    bit take;
    int len, slot, bitN, dp;
    take = 0;
    if (!rstN) begin
      mPos = 0; mOdd = 0; mAligned = 0;
      sT1 = 0; sEven = 0; sOdd = 0; sEn = 0; sSlot = 0; sMask = 0;
      expValid <= 1'b0; expData <= 1'b0;
    end else begin
      if (bitTick) begin
        if (frameSync) begin
          mPos = 0; mOdd = !mOdd; mAligned = 1;
          sT1 = cfgT1; sEven = cfgEven; sOdd = cfgOdd; sEn = cfgEnable;
          sSlot = cfgSlot; sMask = cfgMask;
        end
        len = sT1 ? 193 : 256;
        dp  = sT1 ? mPos - 1 : mPos;
        if (mAligned && sEn && (mOdd ? sOdd : sEven) && mPos < len && dp >= 0
            && sSlot < (sT1 ? 24 : 32)) begin
          slot = dp / 8;
          bitN = 7 - (dp % 8);
          if (slot == sSlot && sMask[bitN]) take = 1;
        end
        if (mPos < 100000) mPos = mPos + 1;
      end
      expValid <= take;
      if (take) expData <= serData;
    end
  end

  always @(negedge clk) begin
    compared++;
    if (linkValid !== expValid || linkData !== expData) begin
      mismatched++;
      $display("FAIL %s: linkValid/linkData=%b/%b expected %b/%b at %0t",
               phase, linkValid, linkData, expValid, expData, $time);
    end
    if (linkValid === 1'b1) pulseCnt++;
  end

  task automatic setCfg(bit t1, bit ev, bit od, bit en, int slot, bit [7:0] mask);
    @(negedge clk);
    cfgT1 = t1; cfgEven = ev; cfgOdd = od; cfgEnable = en;
    cfgSlot = 5'(slot); cfgMask = mask;
  endtask

  task automatic sendBits(int n, bit withSync, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitTick = 1'b1;
      frameSync = (withSync && i == 0);
      serData = 1'($urandom);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        bitTick = 1'b0; frameSync = 1'b0; serData = 1'($urandom);
      end
    end
    @(negedge clk);
    bitTick = 1'b0; frameSync = 1'b0;
  endtask

  task automatic checkCount(string req, int expN);
    repeat (3) @(negedge clk);
    compared++;
    if (pulseCnt != expN) begin
      mismatched++;
      $display("FAIL %s: pulse count %0d expected %0d", req, pulseCnt, expN);
    end
    pulseCnt = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    compared++;
    if (linkValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: linkValid=%b expected 0 in reset", linkValid);
    end
    rstN = 1'b1;
    // R1: no extraction before first sync
    phase = "R1";
    setCfg(0, 1, 1, 1, 0, 8'hFF);
    sendBits(300, 0, 0);
    checkCount("R1", 0);

    // R2: whole slot in 32-slot layout, dense and sparse ticks
    phase = "R2";
    setCfg(0, 1, 1, 1, 5, 8'hFF);
    sendBits(256, 1, 0);
    checkCount("R2", 8);
    sendBits(256, 1, 2);
    checkCount("R2", 8);
    setCfg(0, 1, 1, 1, 0, 8'h80);   // bit 7 coincides with the sync bit
    sendBits(256, 1, 1);
    checkCount("R2", 1);

    // R3: mask selects bit positions, last slot of frame
    phase = "R3";
    setCfg(0, 1, 1, 1, 31, 8'hA5);
    sendBits(256, 1, 0);
    checkCount("R3", 4);
    setCfg(0, 1, 1, 1, 7, 8'h01);
    sendBits(256, 1, 1);
    checkCount("R3", 1);

    // R4: parity selection over frame pairs
    phase = "R4";
    setCfg(0, 1, 0, 1, 3, 8'hFF);
    sendBits(256, 1, 0); sendBits(256, 1, 0);
    checkCount("R4", 8);
    setCfg(0, 0, 1, 1, 3, 8'hFF);
    sendBits(256, 1, 0); sendBits(256, 1, 0);
    checkCount("R4", 8);
    setCfg(0, 0, 0, 1, 3, 8'hFF);
    sendBits(256, 1, 0); sendBits(256, 1, 0);
    checkCount("R4", 0);

    // R5: channel disabled
    phase = "R5";
    setCfg(0, 1, 1, 0, 3, 8'hFF);
    sendBits(256, 1, 0);
    checkCount("R5", 0);

    // R8: 24-slot layout, first and last slots
    phase = "R8";
    setCfg(1, 1, 1, 1, 0, 8'hFF);
    sendBits(193, 1, 0);
    checkCount("R8", 8);
    setCfg(1, 1, 1, 1, 23, 8'hFF);
    sendBits(193, 1, 1);
    checkCount("R8", 8);

    // R6: illegal slot, overlong frame, early sync
    phase = "R6";
    setCfg(1, 1, 1, 1, 30, 8'hFF);
    sendBits(193, 1, 0);
    checkCount("R6", 0);
    setCfg(0, 1, 1, 1, 0, 8'hFF);
    sendBits(256, 1, 0); sendBits(300, 0, 0);
    checkCount("R6", 8);
    setCfg(0, 1, 1, 1, 1, 8'hFF);
    sendBits(12, 1, 0); sendBits(20, 1, 0);
    checkCount("R6", 12);

    // R7: mid-frame change is deferred to next sync
    phase = "R7";
    setCfg(0, 1, 1, 1, 2, 8'hFF);
    sendBits(8, 1, 0);
    setCfg(1, 1, 1, 1, 20, 8'h00);
    sendBits(248, 0, 0);
    checkCount("R7", 8);
    sendBits(193, 1, 0);
    checkCount("R7", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule